// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a compact multi-cycle processor built around one 16-bit accumulator. It reads 16-bit instruction words from a synchronous single-port memory, where the upper four bits select the operation and the lower twelve bits carry either a memory address or an I/O port number. Every instruction passes through a fetch phase, a decode phase and an execute phase, so each instruction takes three clock cycles. Memory read data is valid one cycle after the address is presented.

The instruction set covers accumulator loads and stores, add and subtract, port input and output, unconditional and conditional jumps, a signed compare, and halt. The compare instruction latches greater, equal and less flags, and three conditional jumps test those flags. A separate jump tests the accumulator's sign bit. Once halt executes, the core stays idle until reset.

The core is meant for small control sequencers and teaching fabrics. It is attached to a word memory and to a simple strobed port bus.

Top module: `acc_core`

## Requirements
- R1: While reset is active, and on the first cycle after it, the core presents memory address 0 with no write, no port strobe and `halted` low. The accumulator, the program counter and all three compare flags reset to 0.
- R2: An instruction word holds its opcode in bits 15:12 and its operand in bits 11:0. Each instruction takes three cycles. In the first cycle the program counter is on `mem_addr`. In the second cycle the operand of the returned word is on `mem_addr`. In the third cycle the instruction executes with the operand address still on `mem_addr`.
- R3: Opcode 1 loads the memory word into the accumulator. Opcode 3 adds the memory word to it and opcode 4 subtracts the memory word from it. Both arithmetic results wrap modulo 2^16.
- R4: Opcode 2 asserts `mem_we` for the execute cycle only, with the accumulator on `mem_wdata` and the operand address on `mem_addr`.
- R5: Opcode 5 pulses `io_rd` for one cycle with operand bits 7:0 on `io_port`, and loads `io_rdata` into the accumulator. Opcode 6 pulses `io_wr` for one cycle with the accumulator on `io_wdata` and operand bits 7:0 on `io_port`. At most one of `mem_we`, `io_rd` and `io_wr` is high in any cycle.
- R6: Opcode 7 always jumps to the operand address. Opcode 8 jumps only when accumulator bit 15 is 1. A jump that is not taken continues at the next address.
- R7: Opcode A compares the accumulator with the memory word as signed two's-complement values and latches exactly one of the greater, equal and less flags. Opcodes B, C and D jump when the greater, equal or less flag respectively is set. No other opcode changes the flags.
- R8: Opcode 9 raises `halted`. From then until reset, `halted` stays high and no memory write or port strobe occurs.
- R9: Opcodes 0, E and F change nothing except advancing the program counter by one.
- R10: The program counter is 12 bits wide and steps from address FFF to address 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address to the memory |
| mem_wdata | output | 16 | Write data to the memory (accumulator value) |
| mem_rdata | input | 16 | Read data from the memory, one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| io_port | output | 8 | Port number for input and output transfers |
| io_rd | output | 1 | Input-data strobe |
| io_wr | output | 1 | Output-data strobe |
| io_rdata | input | 16 | Data returned by the addressed port during `io_rd` |
| io_wdata | output | 16 | Data sent to the addressed port during `io_wr` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A wrong program counter appears on `mem_addr` in the next fetch cycle, at most three cycles after the instruction that produced it. A wrong accumulator, or wrong compare flags, stays hidden until a later store, output or jump makes it visible. The test program therefore follows every arithmetic step, compare and sign test with a store, an output or a branch whose target can be seen at the fetch address. A reference model in the bench compares the address, the strobes and the data on every clock. Any sequencing error therefore shows up in the cycle where it occurs.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUB   = 4'h4,
        OP_IN    = 4'h5,
        OP_OUT   = 4'h6,
        OP_JMP   = 4'h7,
        OP_JNEG  = 4'h8,
        OP_HALT  = 4'h9,
        OP_CMP   = 4'hA,
        OP_JGT   = 4'hB,
        OP_JEQ   = 4'hC,
        OP_JLT   = 4'hD,
        OP_RSV_E = 4'hE,
        OP_RSV_F = 4'hF
    } opcode_t;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } core_state_t;

    typedef enum logic [2:0] {
        ALU_NONE,
        ALU_LOAD,
        ALU_ADD,
        ALU_SUB,
        ALU_PORT
    } alu_op_t;

    typedef enum logic [2:0] {
        BR_NONE,
        BR_ALWAYS,
        BR_NEG,
        BR_GT,
        BR_EQ,
        BR_LT
    } branch_t;

    typedef struct packed {
        alu_op_t alu_op;
        branch_t br;
        logic    op_store;
        logic    op_in;
        logic    op_out;
        logic    op_cmp;
        logic    op_halt;
        logic    is_nop;
    } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  opcode_t op,
    output ctrl_t   ctrl
);
    always_comb begin
        ctrl = '{alu_op: ALU_NONE, br: BR_NONE, op_store: 1'b0, op_in: 1'b0,
                 op_out: 1'b0, op_cmp: 1'b0, op_halt: 1'b0, is_nop: 1'b0};
        case (op)
            OP_LOAD:  ctrl.alu_op = ALU_LOAD;
            OP_ADD:   ctrl.alu_op = ALU_ADD;
            OP_SUB:   ctrl.alu_op = ALU_SUB;
            OP_STORE: ctrl.op_store = 1'b1;
            OP_IN: begin
                ctrl.op_in  = 1'b1;
                ctrl.alu_op = ALU_PORT;
            end
            OP_OUT:   ctrl.op_out  = 1'b1;
            OP_JMP:   ctrl.br      = BR_ALWAYS;
            OP_JNEG:  ctrl.br      = BR_NEG;
            OP_HALT:  ctrl.op_halt = 1'b1;
            OP_CMP:   ctrl.op_cmp  = 1'b1;
            OP_JGT:   ctrl.br      = BR_GT;
            OP_JEQ:   ctrl.br      = BR_EQ;
            OP_JLT:   ctrl.br      = BR_LT;
            default:  ctrl.is_nop  = 1'b1;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] port_word,
    output logic [DATA_W-1:0] result,
    output logic              wr_acc,
    output logic              cmp_gt,
    output logic              cmp_eq,
    output logic              cmp_lt
);
    always_comb begin
        wr_acc = 1'b1;
        case (op)
            ALU_LOAD: result = mem_word;
            ALU_ADD:  result = acc + mem_word;
            ALU_SUB:  result = acc - mem_word;
            ALU_PORT: result = port_word;
            default: begin
                result = acc;
                wr_acc = 1'b0;
            end
        endcase
    end

    always_comb begin
        cmp_eq = (acc == mem_word);
        cmp_gt = ($signed(acc) > $signed(mem_word));
        cmp_lt = !cmp_eq && !cmp_gt;
    end
endmodule

// File: rtl/acc_branch.sv
module acc_branch
    import acc_pkg::*;
(
    input  branch_t br,
    input  logic    acc_neg,
    input  logic    flag_gt,
    input  logic    flag_eq,
    input  logic    flag_lt,
    output logic    take
);
    always_comb begin
        case (br)
            BR_ALWAYS: take = 1'b1;
            BR_NEG:    take = acc_neg;
            BR_GT:     take = flag_gt;
            BR_EQ:     take = flag_eq;
            BR_LT:     take = flag_lt;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [PORT_W-1:0] io_port,
    output logic              io_rd,
    output logic              io_wr,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] io_wdata,
    output logic              halted
);
    localparam int OP_W   = DATA_W - ADDR_W;
    localparam int OP_LSB = ADDR_W;

    typedef struct packed {
        core_state_t       state;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic              gt;
        logic              eq;
        logic              lt;
    } regs_t;

    regs_t regs_d, regs_q;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] alu_res;
    logic              alu_wr;
    logic              cmp_gt, cmp_eq, cmp_lt;
    logic              br_take;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] operand;

    assign operand = regs_q.ir[ADDR_W-1:0];
    assign pc_inc  = regs_q.pc + 1'b1;

    acc_decode u_decode (
        .op   (opcode_t'(regs_q.ir[OP_LSB +: OP_W])),
        .ctrl (ctrl)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (ctrl.alu_op),
        .acc       (regs_q.acc),
        .mem_word  (mem_rdata),
        .port_word (io_rdata),
        .result    (alu_res),
        .wr_acc    (alu_wr),
        .cmp_gt    (cmp_gt),
        .cmp_eq    (cmp_eq),
        .cmp_lt    (cmp_lt)
    );

    acc_branch u_branch (
        .br      (ctrl.br),
        .acc_neg (regs_q.acc[DATA_W-1]),
        .flag_gt (regs_q.gt),
        .flag_eq (regs_q.eq),
        .flag_lt (regs_q.lt),
        .take    (br_take)
    );

    always_comb begin
        regs_d   = regs_q;
        mem_addr = regs_q.pc;
        mem_we   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        case (regs_q.state)
            ST_FETCH: begin
                mem_addr     = regs_q.pc;
                regs_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                regs_d.ir    = mem_rdata;
                mem_addr     = mem_rdata[ADDR_W-1:0];
                regs_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr = operand;
                mem_we   = ctrl.op_store;
                io_rd    = ctrl.op_in;
                io_wr    = ctrl.op_out;
                if (alu_wr) begin
                    regs_d.acc = alu_res;
                end
                if (ctrl.op_cmp) begin
                    regs_d.gt = cmp_gt;
                    regs_d.eq = cmp_eq;
                    regs_d.lt = cmp_lt;
                end
                if (ctrl.op_halt) begin
                    regs_d.state = ST_HALT;
                end else begin
                    regs_d.state = ST_FETCH;
                    regs_d.pc    = br_take ? operand : pc_inc;
                end
            end
            default: begin
                regs_d.state = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_FETCH, pc: '0, ir: '0, acc: '0,
                        gt: 1'b0, eq: 1'b0, lt: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_wdata = regs_q.acc;
    assign io_wdata  = regs_q.acc;
    assign io_port   = regs_q.ir[PORT_W-1:0];
    assign halted    = (regs_q.state == ST_HALT);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, io_rd, io_wr}));

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd);

    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_we || io_rd || io_wr));

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_phase_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_FETCH) |=> (regs_q.state == ST_DECODE));

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(regs_q.state == ST_EXEC && ctrl.op_cmp) |=> $stable({regs_q.gt, regs_q.eq, regs_q.lt}));

    p_flags_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_EXEC && ctrl.op_cmp) |=> $onehot({regs_q.gt, regs_q.eq, regs_q.lt}));

    p_nop_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_EXEC && ctrl.is_nop) |=> (regs_q.pc == ADDR_W'($past(regs_q.pc) + 1'b1)));

    p_nop_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_EXEC && ctrl.is_nop) |=> $stable(regs_q.acc));

endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_we;
    logic [7:0]  io_port;
    logic        io_rd;
    logic        io_wr;
    logic [15:0] io_rdata;
    logic [15:0] io_wdata;
    logic        halted;

    always #2.5 clk = ~clk;

    acc_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .io_port(io_port), .io_rd(io_rd),
        .io_wr(io_wr), .io_rdata(io_rdata), .io_wdata(io_wdata), .halted(halted)
    );

    logic [15:0] mem [4096];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [15:0] port_value(input logic [7:0] p);
        return 16'h1000 + 16'(p) * 16'd3;
    endfunction

    assign io_rdata = port_value(io_port);

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model state
    int          m_phase = 0;
    logic [11:0] m_pc = '0;
    logic [15:0] m_acc = '0;
    logic [15:0] m_ir = '0;
    bit          m_gt = 0, m_eq = 0, m_lt = 0;
    int          fetch0_count = 0;
    logic [7:0]  out_port_q[$];
    logic [15:0] out_val_q[$];
    logic [7:0]  in_port_q[$];

    function automatic string tag_for(input int ph, input logic [3:0] op, input logic [11:0] pc);
        if (ph == 3) return "R8";
        if (ph == 0 && pc == 12'h000) return "R10";
        if (ph != 2) return "R2";
        case (op)
            4'h1, 4'h3, 4'h4: return "R3";
            4'h2: return "R4";
            4'h5, 4'h6: return "R5";
            4'h7, 4'h8: return "R6";
            4'hA, 4'hB, 4'hC, 4'hD: return "R7";
            4'h9: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pc = '0; m_acc = '0; m_ir = '0;
            m_gt = 0; m_eq = 0; m_lt = 0;
            chk("R1", "mem_addr in reset", 32'(mem_addr), 32'h0);
            chk("R1", "strobes in reset", 32'({mem_we, io_rd, io_wr, halted}), 32'h0);
        end else begin
            string       t;
            logic [3:0]  op;
            logic [11:0] opd;
            logic [11:0] exp_addr;
            op  = m_ir[15:12];
            opd = m_ir[11:0];
            t   = tag_for(m_phase, op, m_pc);
            exp_addr = (m_phase == 0) ? m_pc : (m_phase == 1) ? mem_rdata[11:0] : opd;
            chk(t, "halted", 32'(halted), 32'(m_phase == 3));
            chk(t, "mem_we", 32'(mem_we), 32'(m_phase == 2 && op == 4'h2));
            chk(t, "io_rd", 32'(io_rd), 32'(m_phase == 2 && op == 4'h5));
            chk(t, "io_wr", 32'(io_wr), 32'(m_phase == 2 && op == 4'h6));
            if (m_phase != 3) chk(t, "mem_addr", 32'(mem_addr), 32'(exp_addr));
            if (mem_we) chk(t, "mem_wdata", 32'(mem_wdata), 32'(m_acc));
            if (io_wr) begin
                chk(t, "io_wdata", 32'(io_wdata), 32'(m_acc));
                out_port_q.push_back(io_port);
                out_val_q.push_back(io_wdata);
            end
            if (io_rd) in_port_q.push_back(io_port);
            if (io_rd || io_wr) chk(t, "io_port", 32'(io_port), 32'(opd[7:0]));
            if (m_phase == 0 && m_pc == 12'h000) fetch0_count++;

            case (m_phase)
                0: m_phase = 1;
                1: begin m_ir = mem_rdata; m_phase = 2; end
                2: begin
                    logic        jump;
                    logic [15:0] rd;
                    rd = mem_rdata;
                    jump = 0;
                    case (op)
                        4'h1: m_acc = rd;
                        4'h3: m_acc = m_acc + rd;
                        4'h4: m_acc = m_acc - rd;
                        4'h5: m_acc = port_value(opd[7:0]);
                        4'h7: jump = 1;
                        4'h8: jump = m_acc[15];
                        4'hA: begin
                            m_gt = $signed(m_acc) > $signed(rd);
                            m_eq = (m_acc == rd);
                            m_lt = $signed(m_acc) < $signed(rd);
                        end
                        4'hB: jump = m_gt;
                        4'hC: jump = m_eq;
                        4'hD: jump = m_lt;
                        default: ;
                    endcase
                    if (op == 4'h9) m_phase = 3;
                    else begin
                        m_phase = 0;
                        m_pc = jump ? opd : m_pc + 12'd1;
                    end
                end
                default: m_phase = 3;
            endcase
        end
    end

    task automatic apply_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        out_port_q.delete(); out_val_q.delete(); in_port_q.delete();
        fetch0_count = 0;
    endtask

    task automatic release_and_run(input int limit);
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        n = 0;
        while (!halted && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (!halted) begin
            vectors++; miscompares++;
            $display("FAIL R8 watchdog actual=running expected=halted");
        end
        repeat (20) @(negedge clk);
    endtask

    initial begin
        // program A
        apply_reset();
        mem[12'h100] = 16'h0005; mem[12'h101] = 16'h0003; mem[12'h102] = 16'hFFFE;
        mem[12'h103] = 16'h7FFF; mem[12'h104] = 16'h0001;
        mem[12'h00] = 16'h1100; mem[12'h01] = 16'h3101; mem[12'h02] = 16'h6010;
        mem[12'h03] = 16'h4102; mem[12'h04] = 16'h2110; mem[12'h05] = 16'h1110;
        mem[12'h06] = 16'h6011; mem[12'h07] = 16'hA101; mem[12'h08] = 16'hD030;
        mem[12'h09] = 16'hC030; mem[12'h0A] = 16'hB00C; mem[12'h0B] = 16'h9000;
        mem[12'h0C] = 16'hA102; mem[12'h0D] = 16'hE000; mem[12'h0E] = 16'hF123;
        mem[12'h0F] = 16'h1103; mem[12'h10] = 16'h3104; mem[12'h11] = 16'h8014;
        mem[12'h12] = 16'h9000; mem[12'h13] = 16'h9000; mem[12'h14] = 16'h6012;
        mem[12'h15] = 16'h532A; mem[12'h16] = 16'h6013; mem[12'h17] = 16'h1100;
        mem[12'h18] = 16'hA100; mem[12'h19] = 16'hC01C; mem[12'h1A] = 16'h9000;
        mem[12'h1B] = 16'h9000; mem[12'h1C] = 16'h1102; mem[12'h1D] = 16'hA101;
        mem[12'h1E] = 16'h0000; mem[12'h1F] = 16'hD022; mem[12'h20] = 16'h9000;
        mem[12'h21] = 16'h9000; mem[12'h22] = 16'h8024; mem[12'h23] = 16'h9000;
        mem[12'h24] = 16'h1104; mem[12'h25] = 16'h8028; mem[12'h26] = 16'h6014;
        mem[12'h27] = 16'h7029; mem[12'h28] = 16'h9000; mem[12'h29] = 16'h9000;
        release_and_run(2000);

        // hand-computed results of program A
        chk("R4", "stored word at 110", 32'(mem[12'h110]), 32'h000A);
        chk("R5", "output count", 32'(out_val_q.size()), 32'd5);
        if (out_val_q.size() == 5) begin
            chk("R3", "out0 value (5+3)", 32'(out_val_q[0]), 32'h0008);
            chk("R5", "out0 port", 32'(out_port_q[0]), 32'h10);
            chk("R3", "out1 value (8-(-2))", 32'(out_val_q[1]), 32'h000A);
            chk("R6", "out2 value after JN", 32'(out_val_q[2]), 32'h8000);
            chk("R5", "out3 value from IN", 32'(out_val_q[3]), 32'h107E);
            chk("R7", "out4 after flag jumps", 32'(out_val_q[4]), 32'h0001);
            chk("R5", "out4 port", 32'(out_port_q[4]), 32'h14);
        end
        chk("R5", "input count", 32'(in_port_q.size()), 32'd1);
        if (in_port_q.size() == 1) chk("R5", "input port low bits", 32'(in_port_q[0]), 32'h2A);
        chk("R8", "halted stays high", 32'(halted), 32'h1);

        // program B: counter wrap
        apply_reset();
        mem[12'h000] = 16'h8005; mem[12'h001] = 16'h1020; mem[12'h002] = 16'h7FFF;
        mem[12'hFFF] = 16'h0000; mem[12'h005] = 16'h9000; mem[12'h020] = 16'h8000;
        release_and_run(500);
        chk("R10", "fetches at address 0", 32'(fetch0_count), 32'd2);
        chk("R8", "halted after wrap program", 32'(halted), 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule